// File: doc/BRIEF.md
# Three-Bank Interrupt Status Aggregator

The block gathers 24 single-bit event inputs from the peripherals of a power-management chip into three 8-bit status banks and drives one level-sensitive interrupt line towards a host processor. A status bit is set on a rising edge of its event input and stays set until the host clears the whole set. Each source has two mask bits. The capture mask stops a source from being recorded at all. The line mask leaves the bit recorded but keeps it from driving the interrupt line.

The host reaches all registers through a byte-wide port: an address, a write strobe with write data, and a read strobe with combinational read data. A multi-byte burst is a run of single-byte accesses at consecutive addresses, so the three status banks come back in order from the lowest byte to the highest. A write of any value to any status address clears all 24 status bits in one step. The usual bring-up sequence masks every source in both mask sets and then clears the status. After that nothing can be recorded or raise the line until the host unmasks a source.

Top module: `pmic_irq_agg`

## Requirements
- R1: Source n (0..23) maps to bit n%8 of status bank n/8. The banks are read at addresses 0, 1 and 2, so reads of 0, 1, 2 in order return the lowest, middle and highest byte.
- R2: A rising edge (input 0 in one cycle, 1 in the next) on a source whose capture-mask bit is 0 sets its status bit at that clock edge. The bit stays set until a clear-all write.
- R3: While a source's capture-mask bit is 1, edges on that source never set its status bit.
- R4: The interrupt output is a register. In each cycle it equals the OR, over all sources, of (status bit AND NOT line-mask bit) as it stood in the previous cycle. A line-masked status bit stays readable but does not raise the output.
- R5: A write of any data value to address 0, 1 or 2 clears all 24 status bits at that clock edge.
- R6: A source edge that arrives in the same cycle as a clear-all write leaves its own status bit set after that edge.
- R7: After reset every status bit is 0, every mask register reads 0xFF and the interrupt output is 0.
- R8: Line-mask banks sit at addresses 4, 5 and 6, and capture-mask banks sit at 8, 9 and 10, in the same bank order as R1. Each reads back the byte last written. A mask bit of 1 disables the source and 0 enables it.
- R9: Source positions 12 and 23 are reserved. Their status bits read 0 and never set, whatever their inputs do.
- R10: Addresses 3, 7 and 11 to 15 read 0x00, and writes to them change no register. Read data is 0x00 while the read strobe is low.
- R11: A source input held high sets its bit only once, on the rising edge. After a clear, the input staying high does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 24 | Peripheral event inputs, source n on bit n |
| addr_i | input | 4 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Registered interrupt line to the host, active high |

## Verification
The bench drives single-source pulses, three sources scattered across all three banks at once, and inputs held high across a clear. Together these separate the bit-to-bank mapping from the edge detection. A behavioural reference model predicts the interrupt line on every clock. Reads after each step show whether the capture mask, the line mask or the reserved positions were the reason an event stayed hidden. A clear issued in the same cycle as a new edge, and writes to every unmapped address, show apart the clear-all priority and the address decode from the ordinary capture path.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    GRP_STS  = 2'd0,
    GRP_LMSK = 2'd1,
    GRP_SMSK = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // Register group selected by the upper address bits.
  function automatic grp_e addr_group(input logic [ADDR_W-1:0] a);
    return grp_e'(a[3:2]);
  endfunction

  // Bank index within a group.
  function automatic logic [1:0] addr_bank(input logic [ADDR_W-1:0] a);
    return a[1:0];
  endfunction

  // True when the address hits a real register.
  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a, input int nbanks);
    return (addr_group(a) != GRP_NONE) && (int'(addr_bank(a)) < nbanks);
  endfunction
endpackage

// File: rtl/pmic_irq_edge.sv
module pmic_irq_edge #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/pmic_irq_bank.sv
module pmic_irq_bank #(
  parameter int           W    = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         clr_all_i,
  input  logic         lmask_we_i,
  input  logic         smask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] lmask_o,
  output logic [W-1:0] smask_o,
  output logic         pend_o
);
  logic [W-1:0] capture;

  // Capture uses the mask value held before any write in this cycle.
  assign capture = rise_i & ~smask_o & ~RSVD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      lmask_o  <= '1;
      smask_o  <= '1;
    end else begin
      status_o <= (clr_all_i ? '0 : status_o) | capture;
      if (lmask_we_i) lmask_o <= wdata_i;
      if (smask_we_i) smask_o <= wdata_i;
    end
  end

  assign pend_o = |(status_o & ~lmask_o);
endmodule

// File: rtl/pmic_irq_agg.sv
module pmic_irq_agg
  import pmic_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_MASK = 24'h80_1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic [BANK_W-1:0]           wr_data_i,
  input  logic                        rd_en_i,
  output logic [BANK_W-1:0]           rd_data_o,
  output logic                        irq_o
);
  localparam int N = NUM_BANKS * BANK_W;

  logic [N-1:0]         rise_all;
  logic [N-1:0]         sts_all;
  logic [N-1:0]         lmsk_all;
  logic [N-1:0]         smsk_all;
  logic [NUM_BANKS-1:0] pend_bank;
  logic                 wr_hit;
  logic                 clr_all;
  grp_e                 wr_grp;

  pmic_irq_edge #(.N(N)) edge_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise_all)
  );

  assign wr_hit  = wr_en_i && addr_mapped(addr_i, NUM_BANKS);
  assign wr_grp  = addr_group(addr_i);
  assign clr_all = wr_hit && (wr_grp == GRP_STS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_hit && (int'(addr_bank(addr_i)) == b);

    pmic_irq_bank #(
      .W(BANK_W),
      .RSVD(RSVD_MASK[b*BANK_W +: BANK_W])
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise_all[b*BANK_W +: BANK_W]),
      .clr_all_i  (clr_all),
      .lmask_we_i (sel && (wr_grp == GRP_LMSK)),
      .smask_we_i (sel && (wr_grp == GRP_SMSK)),
      .wdata_i    (wr_data_i),
      .status_o   (sts_all[b*BANK_W +: BANK_W]),
      .lmask_o    (lmsk_all[b*BANK_W +: BANK_W]),
      .smask_o    (smsk_all[b*BANK_W +: BANK_W]),
      .pend_o     (pend_bank[b])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && addr_mapped(addr_i, NUM_BANKS)) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(addr_bank(addr_i)) == b) begin
          case (addr_group(addr_i))
            GRP_STS:  rd_data_o = sts_all[b*BANK_W +: BANK_W];
            GRP_LMSK: rd_data_o = lmsk_all[b*BANK_W +: BANK_W];
            GRP_SMSK: rd_data_o = smsk_all[b*BANK_W +: BANK_W];
            default:  rd_data_o = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pend_bank;
  end
endmodule

// File: rtl/pmic_irq_agg_chk.sv
module pmic_irq_agg_chk #(
  parameter int          N    = 24,
  parameter int          NB   = 3,
  parameter logic [N-1:0] RSVD = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] sts_all,
  input logic [N-1:0] lmsk_all,
  input logic [N-1:0] smsk_all,
  input logic [N-1:0] rise_all,
  input logic         clr_all,
  input logic         irq_o,
  input logic         rd_en_i,
  input logic [3:0]   addr_i,
  input logic [7:0]   rd_data_o
);
  logic unmapped;
  assign unmapped = (addr_i[3:2] == 2'd3) || (int'(addr_i[1:0]) >= NB);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_all & RSVD) == '0);

  // R3
  masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_all & ~$past(sts_all) & $past(smsk_all)) == '0));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((sts_all & $past(sts_all)) == $past(sts_all)));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && rise_all == '0) |=> (sts_all == '0));

  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_all & ~lmsk_all)) |=> irq_o);

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_all & ~lmsk_all)) |=> !irq_o);

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && unmapped) |-> (rd_data_o == 8'h00));
endmodule

bind pmic_irq_agg pmic_irq_agg_chk #(
  .N(N), .NB(NUM_BANKS), .RSVD(RSVD_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sts_all(sts_all), .lmsk_all(lmsk_all),
  .smsk_all(smsk_all), .rise_all(rise_all), .clr_all(clr_all),
  .irq_o(irq_o), .rd_en_i(rd_en_i), .addr_i(addr_i), .rd_data_o(rd_data_o)
);

// File: tb/pmic_irq_agg_tb.sv
module pmic_irq_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
  );

  // Behavioural reference model
  logic [23:0] m_sts, m_lm, m_sm, m_prev;
  logic        m_irq;
  logic [23:0] m_next;
  bit          m_any;
  int          m_k;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = '0; m_lm = '1; m_sm = '1; m_prev = '0; m_irq = 0;
    end else begin
      m_any = 0;
      for (int i = 0; i < 24; i++) if (m_sts[i] && !m_lm[i]) m_any = 1;
      m_next = m_sts;
      if (wr_en && addr <= 4'd2) m_next = '0;
      for (int i = 0; i < 24; i++)
        if (src[i] && !m_prev[i] && !m_sm[i] && i != 12 && i != 23) m_next[i] = 1'b1;
      if (wr_en && addr >= 4'd4 && addr <= 4'd6) begin
        m_k = int'(addr) - 4; m_lm[8*m_k +: 8] = wdata;
      end
      if (wr_en && addr >= 4'd8 && addr <= 4'd10) begin
        m_k = int'(addr) - 8; m_sm[8*m_k +: 8] = wdata;
      end
      m_prev = src;
      m_sts  = m_next;
      m_irq  = m_any;
    end
  end

  function automatic logic [7:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_sts[7:0];   4'd1: return m_sts[15:8];  4'd2:  return m_sts[23:16];
      4'd4: return m_lm[7:0];    4'd5: return m_lm[15:8];   4'd6:  return m_lm[23:16];
      4'd8: return m_sm[7:0];    4'd9: return m_sm[15:8];   4'd10: return m_sm[23:16];
      default: return 8'h00;
    endcase
  endfunction

  // Per-clock comparison of the interrupt line (R4)
  always @(negedge clk) begin
    cycles++;
    if (cmp_on && rst_n) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R4 irq line: actual %0b expected %0b at cycle %0d", irq, m_irq, cycles);
      end
    end
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [23:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #(CLK_PERIOD/4);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rd_data, exp);
    end
    if (model_rd(a) !== exp) begin
      errors++;
      $display("FAIL %s model addr %0d: actual %02h expected %02h", tag, a, model_rd(a), exp);
    end
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(1);

    // R7 reset state
    for (int a = 0; a < 3; a++) chk_rd(4'(a), 8'h00, "R7 status");
    for (int a = 4; a < 7; a++) chk_rd(4'(a), 8'hFF, "R7 line mask");
    for (int a = 8; a < 11; a++) chk_rd(4'(a), 8'hFF, "R7 capture mask");
    chk_irq(1'b0, "R7");

    // R7/R3 masked at reset: edges are not captured
    pulse(24'h00_0001);
    idle(1);
    chk_rd(4'd0, 8'h00, "R3 masked at reset");

    // R8 unmask all, check readback
    for (int a = 4; a < 7; a++) wr(4'(a), 8'h00);
    for (int a = 8; a < 11; a++) wr(4'(a), 8'h00);
    chk_rd(4'd5, 8'h00, "R8 line mask readback");
    chk_rd(4'd9, 8'h00, "R8 capture mask readback");

    // R2 single edge captured and held
    pulse(24'h00_0001);
    idle(3);
    chk_rd(4'd0, 8'h01, "R2 capture");
    chk_rd(4'd0, 8'h01, "R2 sticky");
    chk_irq(1'b1, "R4 raise");

    // R5 clear by writing arbitrary data to the highest status address
    wr(4'd2, 8'h5A);
    chk_rd(4'd0, 8'h00, "R5 clear");
    idle(1);
    chk_irq(1'b0, "R4 drop");

    // R1 bank mapping and burst order
    pulse(24'h10_0220);
    idle(1);
    chk_rd(4'd0, 8'h20, "R1 bank A");
    chk_rd(4'd1, 8'h02, "R1 bank B");
    chk_rd(4'd2, 8'h10, "R1 bank C");
    wr(4'd1, 8'h00);

    // R9 reserved positions
    pulse(24'h80_1000);
    idle(2);
    chk_rd(4'd1, 8'h00, "R9 reserved 12");
    chk_rd(4'd2, 8'h00, "R9 reserved 23");
    chk_irq(1'b0, "R9");

    // R3 capture mask per bit
    wr(4'd8, 8'h01);
    pulse(24'h00_0003);
    idle(1);
    chk_rd(4'd0, 8'h02, "R3 capture mask");
    wr(4'd8, 8'h00);
    wr(4'd0, 8'hFF);

    // R4 line mask hides but keeps status
    wr(4'd5, 8'hFF);
    pulse(24'h00_0100);
    idle(3);
    chk_rd(4'd1, 8'h01, "R4 masked status kept");
    chk_irq(1'b0, "R4 line masked");
    wr(4'd5, 8'h00);
    idle(1);
    chk_irq(1'b1, "R4 line unmasked");
    wr(4'd0, 8'h00);

    // R6 edge in the same cycle as clear
    pulse(24'h00_0010);
    @(negedge clk); src[3] = 1'b1; addr = 4'd1; wdata = 8'h33; wr_en = 1'b1;
    @(negedge clk); src[3] = 1'b0; wr_en = 1'b0;
    chk_rd(4'd0, 8'h08, "R6 new event wins");

    // R11 held high input does not re-arm
    @(negedge clk); src[6] = 1'b1;
    idle(2);
    chk_rd(4'd0, 8'h48, "R11 first edge");
    wr(4'd0, 8'h00);
    idle(3);
    chk_rd(4'd0, 8'h00, "R11 held high");
    @(negedge clk); src[6] = 1'b0;

    // R8 pattern readback
    wr(4'd6, 8'hA5);
    wr(4'd10, 8'h3C);
    chk_rd(4'd6, 8'hA5, "R8 line mask C");
    chk_rd(4'd10, 8'h3C, "R8 capture mask C");

    // R10 unmapped writes ignored and read zero
    pulse(24'h00_0004);
    idle(1);
    wr(4'd3, 8'h00); wr(4'd7, 8'h12); wr(4'd11, 8'h34); wr(4'd15, 8'h56);
    chk_rd(4'd3, 8'h00, "R10 unmapped 3");
    chk_rd(4'd7, 8'h00, "R10 unmapped 7");
    chk_rd(4'd11, 8'h00, "R10 unmapped 11");
    chk_rd(4'd15, 8'h00, "R10 unmapped 15");
    chk_rd(4'd0, 8'h04, "R10 status untouched");
    chk_rd(4'd6, 8'hA5, "R10 line mask untouched");
    chk_rd(4'd10, 8'h3C, "R10 capture mask untouched");
    @(negedge clk); addr = 4'd0; rd_en = 1'b0;
    #(CLK_PERIOD/4);
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R10 strobe low: actual %02h expected 00", rd_data);
    end

    idle(2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule